// File: doc/BRIEF.md
# Flow-Through Burst SRAM Front End

This block is the synchronous front end of a burst static RAM whose read path has no output register. On each rising clock edge it captures the address, the two address strobes, the burst-advance input, the three chip selects, the write enables and the write data. It decides whether the cycle starts a burst, continues one, holds one in place, or leaves the device deselected. A two-bit burst counter steps through four consecutive words, in either interleaved or linear order. A small internal byte-lane array stands in for the memory core.

Read data for the registered address reaches the data output in the same cycle, straight from the array. An asynchronous output enable gates the output, and a drive-enable output tells the pad buffer when to drive. Writes are held in a register and committed to the array at the following edge. A sleep input passes through a two-flop synchroniser. While it is in effect, clock edges do nothing, and the array contents and the burst position are kept.

Top module: `sram_ft_front`

## Requirements
- R1: While reset is high, and at the first edge after it falls, no write reaches the array and `dout_drive_o` stays low.
- R2: A burst start is an edge where either `ctrl_stb_n` is low, or `proc_stb_n` and `sel0_n` are both low. At a burst start the device is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. With any other combination of the three selects, the start deselects the device: nothing is written and nothing is driven in the following cycle.
- R3: Once deselected, the device ignores advance, write and read cycles until the next selected burst start. Memory is left unchanged and nothing is driven.
- R4: `gwr_n`=0 in a write-capable cycle writes both 9-bit lanes (lane k is data bits 9k+8..9k), whatever `bw_gate_n` and `lane_we_n` are.
- R5: When `gwr_n`=1 and `bw_gate_n`=0, only the lanes whose `lane_we_n` bit is 0 are written. The other lanes keep their contents.
- R6: The cycle is a read when `gwr_n`=1 and `bw_gate_n`=1. It is also a read when `gwr_n`=1, `bw_gate_n`=0 and every `lane_we_n` bit is 1.
- R7: A burst started by `proc_stb_n` is always a read, even with write enables asserted. When both strobes are low, the `proc_stb_n` start takes precedence.
- R8: Read data for the address registered at an edge appears on `dout_o` in the cycle right after that edge. It includes a write committed at that same edge.
- R9: `dout_drive_o` follows `oe_n` with no clock: it is high only when `oe_n`=0 in a read cycle. It is low during write cycles, and `dout_o` is zero whenever `dout_drive_o` is low.
- R10: The burst counter starts at 0 and advances on edges with `adv_n`=0. It holds on edges with `adv_n`=1, and it wraps after 3. The low two address bits are start XOR count when `order_i`=1, and start plus count modulo 4 when `order_i`=0. The upper address bits do not change during a burst.
- R11: `sleep_i` passes through two flops. Edges at which the synchronised sleep is high register nothing. While the synchronised sleep is high, nothing is driven and the array contents and the burst position are preserved. After wake-up the burst continues from the address where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address captured at a burst start |
| proc_stb_n | input | 1 | Processor-side address strobe, active low, read-only starts |
| ctrl_stb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | First chip select, active low; also qualifies the processor strobe |
| sel1 | input | 1 | Second chip select, active high |
| sel2_n | input | 1 | Third chip select, active low |
| gwr_n | input | 1 | Global write, active low, all lanes |
| bw_gate_n | input | 1 | Gate for the per-lane write enables, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| wdata_i | input | LANES*LANE_W | Write data, captured with the cycle |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| dout_o | output | LANES*LANE_W | Flow-through read data, zero when not driven |
| dout_drive_o | output | 1 | Drive enable for the external three-state buffer |

## Verification
The assertions assume that `order_i` is changed only between bursts and is steady while the device sleeps. They also assume that `sleep_i` is low during reset, so that the synchroniser starts clean. The stimulus sets `order_i` only before a new start, raises `sleep_i` only after reset, and changes all inputs a quarter period after the rising edge, so that the setup and hold windows of the synchroniser are never at issue. The reference model follows the same two-edge sleep latency. While the model sleeps, the stimulus keeps applying strobes and writes, to show that they are dropped.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;

  // Burst ordering selected by the order input.
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // Kind of cycle registered at the last edge.
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

endpackage

// File: rtl/sram_ft_sync.sv
module sram_ft_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[STAGES-2:0], d_i};
  end

  assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/sram_ft_burst_seq.sv
module sram_ft_burst_seq
  import sram_ft_pkg::*;
#(
  parameter int BW = 2
) (
  input  logic [BW-1:0] start_i,
  input  logic [BW-1:0] count_i,
  input  logic          order_i,
  output logic [BW-1:0] lsb_o
);
  burst_order_e order;

  always_comb begin
    order = burst_order_e'(order_i);
    if (order == ORD_INTERLEAVE) lsb_o = start_i ^ count_i;
    else                         lsb_o = start_i + count_i;
  end
endmodule

// File: rtl/sram_ft_wdec.sv
module sram_ft_wdec #(
  parameter int LANES = 2
) (
  input  logic             gwr_n,
  input  logic             gate_n,
  input  logic [LANES-1:0] lane_n,
  output logic             is_write_o,
  output logic [LANES-1:0] mask_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask_o[g] = !gwr_n || (!gate_n && !lane_n[g]);
  end

  assign is_write_o = |mask_o;
endmodule

// File: rtl/sram_ft_array.sv
module sram_ft_array #(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [LANES-1:0]        lane_en_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i && lane_en_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_ft_ctrl.sv
module sram_ft_ctrl
  import sram_ft_pkg::*;
#(
  parameter int AW    = 6,
  parameter int BW    = 2,
  parameter int LANES = 2,
  parameter int DW    = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr_i,
  input  logic             proc_stb_n,
  input  logic             ctrl_stb_n,
  input  logic             adv_n,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             is_write_i,
  input  logic [LANES-1:0] wmask_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             asleep_i,
  output logic [AW-1:0]    base_o,
  output logic [BW-1:0]    count_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic [LANES-1:0] mask_o,
  output logic [DW-1:0]    wdata_o,
  output logic             live_o
);
  cyc_e             cyc_q;
  logic             live_q;
  logic [AW-1:0]    base_q;
  logic [BW-1:0]    cnt_q;
  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    wd_q;
  logic             start_proc, start_any, chip_on;

  always_comb begin
    start_proc = !proc_stb_n && !sel0_n;
    start_any  = start_proc || !ctrl_stb_n;
    chip_on    = !sel0_n && sel1 && !sel2_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= CYC_IDLE;
      live_q <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
      wd_q   <= '0;
    end else if (asleep_i) begin
      cyc_q <= CYC_IDLE;
    end else begin
      mask_q <= wmask_i;
      wd_q   <= wdata_i;
      if (start_any) begin
        if (chip_on) begin
          live_q <= 1'b1;
          base_q <= addr_i;
          cnt_q  <= '0;
          cyc_q  <= (start_proc || !is_write_i) ? CYC_READ : CYC_WRITE;
        end else begin
          live_q <= 1'b0;
          cyc_q  <= CYC_IDLE;
        end
      end else if (live_q) begin
        if (!adv_n) cnt_q <= cnt_q + 1'b1;
        cyc_q <= is_write_i ? CYC_WRITE : CYC_READ;
      end else begin
        cyc_q <= CYC_IDLE;
      end
    end
  end

  assign base_o  = base_q;
  assign count_o = cnt_q;
  assign rd_o    = (cyc_q == CYC_READ);
  assign wr_o    = (cyc_q == CYC_WRITE);
  assign mask_o  = mask_q;
  assign wdata_o = wd_q;
  assign live_o  = live_q;
endmodule

// File: rtl/sram_ft_front.sv
module sram_ft_front #(
  parameter int AW          = 6,
  parameter int LANE_W      = 9,
  parameter int LANES       = 2,
  parameter int BW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AW-1:0]           addr_i,
  input  logic                    proc_stb_n,
  input  logic                    ctrl_stb_n,
  input  logic                    adv_n,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    gwr_n,
  input  logic                    bw_gate_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_n,
  input  logic                    order_i,
  input  logic                    sleep_i,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic                    dout_drive_o
);
  localparam int DW = LANES * LANE_W;

  logic             sleep_sync;
  logic             is_write;
  logic [LANES-1:0] wmask;
  logic [AW-1:0]    base;
  logic [BW-1:0]    count;
  logic [BW-1:0]    lsb;
  logic             rd_cyc;
  logic             mem_we;
  logic [LANES-1:0] mem_mask;
  logic [DW-1:0]    mem_wdata;
  logic [DW-1:0]    rdata;
  logic [AW-1:0]    cur_addr;
  logic             burst_live;

  sram_ft_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(sleep_i), .q_o(sleep_sync)
  );

  sram_ft_wdec #(.LANES(LANES)) u_wdec (
    .gwr_n(gwr_n), .gate_n(bw_gate_n), .lane_n(lane_we_n),
    .is_write_o(is_write), .mask_o(wmask)
  );

  sram_ft_ctrl #(.AW(AW), .BW(BW), .LANES(LANES), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .is_write_i(is_write), .wmask_i(wmask), .wdata_i(wdata_i),
    .asleep_i(sleep_sync),
    .base_o(base), .count_o(count), .rd_o(rd_cyc), .wr_o(mem_we),
    .mask_o(mem_mask), .wdata_o(mem_wdata), .live_o(burst_live)
  );

  sram_ft_burst_seq #(.BW(BW)) u_seq (
    .start_i(base[BW-1:0]), .count_i(count), .order_i(order_i), .lsb_o(lsb)
  );

  assign cur_addr = {base[AW-1:BW], lsb};

  sram_ft_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .we_i(mem_we), .lane_en_i(mem_mask), .addr_i(cur_addr),
    .wdata_i(mem_wdata), .rdata_o(rdata)
  );

  assign dout_drive_o = rd_cyc && !oe_n && !sleep_sync;
  assign dout_o       = dout_drive_o ? rdata : '0;
endmodule

// File: rtl/sram_ft_front_chk.sv
module sram_ft_front_chk #(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             proc_stb_n,
  input logic             ctrl_stb_n,
  input logic             adv_n,
  input logic             sel0_n,
  input logic             sel1,
  input logic             sel2_n,
  input logic             gwr_n,
  input logic             oe_n,
  input logic             order_i,
  input logic             dout_drive_o,
  input logic             sleep_sync,
  input logic             mem_we,
  input logic [LANES-1:0] mem_mask,
  input logic [AW-1:0]    cur_addr,
  input logic             burst_live
);
  logic start_any, chip_on;
  assign start_any = (!proc_stb_n && !sel0_n) || !ctrl_stb_n;
  assign chip_on   = !sel0_n && sel1 && !sel2_n;

  p_desel_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start_any && !chip_on) |=> (!mem_we && !dout_drive_o));

  p_desel_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (!burst_live && !start_any) |=> !burst_live);

  p_global_all_lanes_r4: assert property (@(posedge clk) disable iff (rst)
    (!sleep_sync && !ctrl_stb_n && !(!proc_stb_n && !sel0_n) && chip_on && !gwr_n)
    |=> (mem_we && (&mem_mask)));

  p_proc_reads_r7: assert property (@(posedge clk) disable iff (rst)
    (!sleep_sync && !proc_stb_n && !sel0_n) |=> !mem_we);

  p_oe_gate_r9: assert property (@(posedge clk) disable iff (rst)
    dout_drive_o |-> !oe_n);

  p_no_drive_on_write_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !dout_drive_o);

  p_suspend_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (!sleep_sync && burst_live && !start_any && adv_n)
    |=> ($stable(cur_addr) || !$stable(order_i)));

  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    sleep_sync |-> !dout_drive_o);

  p_sleep_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    sleep_sync |=> !mem_we);

  p_sleep_keeps_pos_r11: assert property (@(posedge clk) disable iff (rst)
    sleep_sync |=> (($stable(cur_addr) || !$stable(order_i)) && $stable(burst_live)));
endmodule

bind sram_ft_front sram_ft_front_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
  .adv_n(adv_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
  .gwr_n(gwr_n), .oe_n(oe_n), .order_i(order_i),
  .dout_drive_o(dout_drive_o), .sleep_sync(sleep_sync), .mem_we(mem_we),
  .mem_mask(mem_mask), .cur_addr(cur_addr), .burst_live(burst_live)
);

// File: tb/sim_sram_ft_front.sv
module sim_sram_ft_front;
  localparam int AW = 6, LW = 9, LN = 2, DW = 18, DEPTH = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic [AW-1:0] addr_i;
  logic          proc_stb_n, ctrl_stb_n, adv_n, sel0_n, sel1, sel2_n;
  logic          gwr_n, bw_gate_n, oe_n, order_i, sleep_i;
  logic [LN-1:0] lane_we_n;
  logic [DW-1:0] wdata_i, dout_o;
  logic          dout_drive_o;

  sram_ft_front u0 (
    .clk(clk), .rst(rst), .addr_i(addr_i), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .gwr_n(gwr_n), .bw_gate_n(bw_gate_n),
    .lane_we_n(lane_we_n), .wdata_i(wdata_i), .oe_n(oe_n),
    .order_i(order_i), .sleep_i(sleep_i), .dout_o(dout_o),
    .dout_drive_o(dout_drive_o)
  );

  int total = 0;
  int bad = 0;
  string req = "R1";

  // reference model state
  logic [DW-1:0] mm [DEPTH];
  bit            m_s1, m_s2, m_live, m_rd, m_wr;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic [LN-1:0] m_mask;
  logic [DW-1:0] m_wd;

  function automatic logic [DW-1:0] fv(int a);
    return {6'(a), 12'(a * 37 + 5)};
  endfunction

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] l;
    l = order_i ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], l};
  endfunction

  task automatic check(string r, logic [DW:0] got, logic [DW:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", r, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit bp, bc, on, w;
    logic [LN-1:0] m;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_live = 0; m_rd = 0; m_wr = 0; m_cnt = 0; m_base = 0;
    end else begin
      if (m_wr)
        for (int l = 0; l < LN; l++)
          if (m_mask[l]) mm[m_addr()][l*LW +: LW] = m_wd[l*LW +: LW];
      if (m_s2) begin
        m_rd = 0; m_wr = 0;
      end else begin
        bp = !proc_stb_n && !sel0_n;
        bc = !ctrl_stb_n;
        on = !sel0_n && sel1 && !sel2_n;
        m  = !gwr_n ? {LN{1'b1}} : (!bw_gate_n ? ~lane_we_n : '0);
        w  = (m != 0);
        if (bp || bc) begin
          if (on) begin
            m_live = 1; m_base = addr_i; m_cnt = 0;
            m_rd = bp ? 1'b1 : !w; m_wr = bp ? 1'b0 : w;
          end else begin
            m_live = 0; m_rd = 0; m_wr = 0;
          end
        end else if (m_live) begin
          if (!adv_n) m_cnt = m_cnt + 2'd1;
          m_rd = !w; m_wr = w;
        end else begin
          m_rd = 0; m_wr = 0;
        end
        m_mask = m; m_wd = wdata_i;
      end
      m_s2 = m_s1; m_s1 = sleep_i;
    end
  endtask

  task automatic compare();
    bit ed;
    logic [DW-1:0] exd;
    ed  = m_rd && !oe_n && !m_s2;
    exd = ed ? mm[m_addr()] : '0;
    check(req, {dout_drive_o, dout_o}, {ed, exd});
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #2;
    compare();
  endtask

  task automatic idle();
    proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1;
    sel0_n = 0; sel1 = 1; sel2_n = 0;
    gwr_n = 1; bw_gate_n = 1; lane_we_n = '1;
  endtask

  task automatic read_start(int a);
    idle(); proc_stb_n = 0; addr_i = 6'(a);
    tick();
    proc_stb_n = 1;
  endtask

  task automatic expect_read(string r, logic [DW-1:0] v);
    check(r, {dout_drive_o, dout_o}, {1'b1, v});
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; idle(); addr_i = 0; wdata_i = 0; oe_n = 0; order_i = 0; sleep_i = 0;
    req = "R1";
    repeat (3) tick();
    rst = 0;
    tick();
    check("R1", {dout_drive_o, dout_o}, '0);

    // fill the array with linear write bursts (R4 global write)
    req = "R4";
    order_i = 0;
    for (int a = 0; a < DEPTH; a += 4) begin
      idle(); ctrl_stb_n = 0; gwr_n = 0; addr_i = 6'(a); wdata_i = fv(a);
      tick();
      check("R9", {1'b0, dout_drive_o}, '0);
      ctrl_stb_n = 1;
      for (int k = 1; k < 4; k++) begin
        adv_n = 0; wdata_i = fv(a + k);
        tick();
      end
    end
    idle(); tick();

    // interleaved burst from low bits 2 (R10, R8)
    req = "R10";
    order_i = 1;
    read_start(22); expect_read("R8", fv(22));
    adv_n = 0; tick(); expect_read("R10", fv(23));
    tick(); expect_read("R10", fv(20));
    tick(); expect_read("R10", fv(21));
    adv_n = 1; tick(); expect_read("R10", fv(21));
    adv_n = 0; tick(); expect_read("R10", fv(22));

    // asynchronous output enable (R9)
    adv_n = 1; tick();
    oe_n = 1; #1;
    check("R9", {dout_drive_o, dout_o}, '0);
    oe_n = 0; #1;
    expect_read("R9", fv(22));
    idle(); tick();

    // linear burst from low bits 3
    order_i = 0;
    read_start(43); expect_read("R10", fv(43));
    adv_n = 0; tick(); expect_read("R10", fv(40));
    tick(); expect_read("R10", fv(41));
    tick(); expect_read("R10", fv(42));
    idle(); tick();

    // lane write of lane 0 only (R5)
    req = "R5";
    idle(); ctrl_stb_n = 0; addr_i = 8; bw_gate_n = 0; lane_we_n = 2'b10;
    wdata_i = 18'h3FFFF;
    tick();
    check("R9", {1'b0, dout_drive_o}, '0);
    read_start(8); expect_read("R5", {fv(8)[17:9], 9'h1FF});
    idle(); tick();

    // read decodes (R6)
    req = "R6";
    idle(); ctrl_stb_n = 0; addr_i = 12; bw_gate_n = 0; lane_we_n = 2'b11;
    wdata_i = 18'h15555;
    tick(); expect_read("R6", fv(12));
    idle(); ctrl_stb_n = 0; addr_i = 12; bw_gate_n = 1; lane_we_n = 2'b00;
    tick(); expect_read("R6", fv(12));
    idle(); tick();

    // global write overrides lane enables (R4)
    req = "R4";
    idle(); ctrl_stb_n = 0; addr_i = 16; gwr_n = 0; lane_we_n = 2'b11;
    wdata_i = 18'h2AAAA;
    tick();
    idle(); ctrl_stb_n = 0; addr_i = 17; gwr_n = 0; bw_gate_n = 0; lane_we_n = 2'b10;
    wdata_i = 18'h12345;
    tick();
    read_start(16); expect_read("R4", 18'h2AAAA);
    read_start(17); expect_read("R4", 18'h12345);

    // processor strobe always reads (R7)
    req = "R7";
    idle(); proc_stb_n = 0; addr_i = 24; gwr_n = 0; wdata_i = 18'h00BAD;
    tick(); expect_read("R7", fv(24));
    idle(); proc_stb_n = 0; ctrl_stb_n = 0; addr_i = 25; gwr_n = 0;
    tick(); expect_read("R7", fv(25));
    read_start(24); expect_read("R7", fv(24));
    read_start(25); expect_read("R7", fv(25));

    // chip select combinations (R2)
    req = "R2";
    for (int v = 0; v < 4; v++) begin
      read_start(28);
      idle(); addr_i = 29;
      if (v == 3) proc_stb_n = 0; else ctrl_stb_n = 0;
      if (v == 0) sel0_n = 1;
      if (v == 1 || v == 3) sel1 = 0;
      if (v == 2) sel2_n = 1;
      tick();
      check("R2", {dout_drive_o, dout_o}, '0);
    end

    // deselect persists (R3)
    req = "R3";
    idle(); adv_n = 0; gwr_n = 0; wdata_i = 18'h0DEAD;
    repeat (3) begin
      tick();
      check("R3", {dout_drive_o, dout_o}, '0);
    end
    order_i = 1;
    read_start(28); expect_read("R3", fv(28));
    adv_n = 0;
    for (int k = 1; k < 4; k++) begin
      tick(); expect_read("R3", fv(28 + k));
    end
    idle(); tick();

    // sleep (R11)
    req = "R11";
    read_start(32);
    adv_n = 0; tick(); expect_read("R11", fv(33));
    sleep_i = 1;
    tick(); tick();
    idle(); ctrl_stb_n = 0; gwr_n = 0; addr_i = 50; wdata_i = 18'h00001;
    repeat (4) begin
      tick();
      check("R11", {dout_drive_o, dout_o}, '0);
    end
    idle(); sleep_i = 0;
    tick(); tick();
    check("R11", {dout_drive_o, dout_o}, '0);
    tick(); expect_read("R11", fv(35));
    read_start(50); expect_read("R11", fv(50));
    idle(); tick();

    // final sweep of the whole array against the model
    req = "R8";
    order_i = 0;
    for (int a = 0; a < DEPTH; a += 4) begin
      read_start(a);
      adv_n = 0;
      repeat (3) tick();
    end
    idle(); tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule